// File: doc/BRIEF.md
# I2C Slave Byte Status Generator

This block sits on the slave side of an I2C port and follows the serial clock through each byte. It counts rising edges of the already synchronized and filtered SCL and decides when a byte is finished. It then raises a sticky byte-complete flag and a one-cycle interrupt pulse. The interrupt is also held as a level until software acknowledges it. The point of completion depends on the direction of transfer. When the slave sends, a byte ends on the edge that samples the master's acknowledge. When it receives, a byte ends on the edge of the last data bit.

Two more flags are set at that same moment. One tells software that the finished byte was the slave address, which is the first byte after a start. The other reports, after a byte the slave has sent, that the acknowledge bit has arrived; its value is kept on a separate output. Software clears all flags with a one-cycle clear pulse. A start condition also clears them and resets the count.

Top module: `i2c_byte_status`

## Requirements
- R1: After reset all outputs are 0. The reset input is asynchronous and active low, and its release is synchronized to `clk` over two stages.
- R2: Only a 0-to-1 change of `scl_s` between two consecutive clock cycles counts as an edge. Holding SCL high or driving it low counts nothing. Each result appears in the clock cycle after the cycle in which the edge is seen.
- R3: With `xmit`=1 (slave transmits), a byte completes on the ninth rising edge counted from a start or from the end of the previous nine-edge frame.
- R4: With `xmit`=0 (slave receives), a byte completes on the eighth rising edge. The ninth (acknowledge) edge produces no completion and does not count toward the next byte: the count always wraps after nine edges.
- R5: `addr_flag` is set together with the first byte completion after a start. Later completions before the next start do not set it.
- R6: `lrb_flag` is set only by a completion with `xmit`=1, and `lrb_val` then takes the value of `sda_s` sampled on that edge. A receive completion leaves both unchanged. `lrb_val` keeps its last captured value until the next such capture.
- R7: Every completion gives exactly one one-cycle `irq_pulse` and sets `irq_level`. `irq_level` stays at 1 until a clear or a start.
- R8: A one-cycle `stat_clr` pulse clears `byte_done`, `addr_flag`, `lrb_flag` and `irq_level`. If a completion falls in the same cycle as the clear, the completion wins and its flags are set.
- R9: A `start_det` pulse resets the edge count to zero, clears the four sticky flags and marks the next completed byte as the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_s | input | 1 | Synchronized, filtered SCL |
| sda_s | input | 1 | Synchronized, filtered SDA |
| xmit | input | 1 | 1 = slave transmits, 0 = slave receives |
| start_det | input | 1 | One-cycle pulse: start condition seen |
| stat_clr | input | 1 | One-cycle pulse: software acknowledge |
| byte_done | output | 1 | Sticky byte-complete flag |
| addr_flag | output | 1 | Sticky flag: completed byte was the address |
| lrb_flag | output | 1 | Sticky flag: acknowledge bit after a transmitted byte received |
| lrb_val | output | 1 | Captured acknowledge bit value |
| irq_pulse | output | 1 | One-cycle interrupt per completion |
| irq_level | output | 1 | Interrupt level held until cleared |

## Verification
Every result is due one clock cycle after the cycle in which `scl_s` is first seen high. The bench drives inputs on the falling clock edge, so the edge is registered on the next rising edge and all flags and the pulse are read at the falling edge after that. The driver models each rising edge as it drives it. When the model predicts a completion, the driver pushes the expected flag set into a queue. The monitor pops one item for each `irq_pulse` it sees at a falling edge. A pulse with no item waiting, a pulse two cycles wide, or items left over at the end all count as failures. Clears and starts are checked at the falling edge after the pulse, which is the first cycle their effect is visible.

// File: rtl/i2c_bstat_pkg.sv
package i2c_bstat_pkg;

  localparam int unsigned BSTAT_DATA_BITS = 8;
  localparam int unsigned BSTAT_SYNC_STAGES = 2;

  // edges in one full frame: data bits plus the acknowledge bit
  function automatic int unsigned frame_edges(input int unsigned data_bits);
    return data_bits + 1;
  endfunction

endpackage

// File: rtl/i2c_bstat_rsync.sv
module i2c_bstat_rsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  generate
    if (STAGES <= 1) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) q <= 1'b0;
        else         q <= 1'b1;
      end
      assign srst_n = q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      logic [STAGES-1:0] sh_d;
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
      end
      assign srst_n = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2c_bstat_edge.sv
module i2c_bstat_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  output logic rise
);

  logic scl_q;
  logic scl_d;

  always_comb scl_d = scl_s;

  // reset to 1: an idle bus is high, so no edge is seen at release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) scl_q <= 1'b1;
    else        scl_q <= scl_d;
  end

  assign rise = scl_s & ~scl_q;

  // R2: an edge is never reported in two consecutive cycles
  a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/i2c_bstat_count.sv
module i2c_bstat_count #(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic start,
  input  logic xmit,
  output logic cmpl
);

  localparam int unsigned EDGES = i2c_bstat_pkg::frame_edges(DATA_BITS);
  localparam int unsigned CNT_W = $clog2(EDGES + 1);
  localparam logic [CNT_W-1:0] TX_END = CNT_W'(EDGES);
  localparam logic [CNT_W-1:0] RX_END = CNT_W'(DATA_BITS);
  localparam logic [CNT_W-1:0] WRAP_AT = CNT_W'(EDGES);
  localparam logic [CNT_W-1:0] LAST_Q = CNT_W'(EDGES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] inc;
  logic [CNT_W-1:0] target;
  logic             cnt_en;

  always_comb begin
    target = xmit ? TX_END : RX_END;
    inc    = cnt_q + 1'b1;
    cnt_en = start | rise;
    cnt_d  = cnt_q;
    cmpl   = 1'b0;
    if (start) begin
      cnt_d = '0;
    end else if (rise) begin
      cmpl  = (inc == target);
      cnt_d = (inc == WRAP_AT) ? '0 : inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R9: a start leaves the count at zero
  a_r9_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0));

  // R4: the count wraps after the acknowledge edge whatever the direction
  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !start && cnt_q == LAST_Q) |=> (cnt_q == '0));

  // R2: the count only moves on an edge or a start
  a_r2_count_moves: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise || start) |=> $stable(cnt_q));

endmodule

// File: rtl/i2c_bstat_flags.sv
module i2c_bstat_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic cmpl,
  input  logic start,
  input  logic clr,
  input  logic xmit,
  input  logic sda_s,
  output logic done_o,
  output logic addr_o,
  output logic lrb_o,
  output logic val_o,
  output logic irq_p_o,
  output logic irq_l_o
);

  logic done_q, addr_q, lrb_q, val_q, irqp_q, irql_q, arm_q;
  logic done_d, addr_d, lrb_d, val_d, irqp_d, irql_d, arm_d;

  always_comb begin
    done_d = done_q;
    addr_d = addr_q;
    lrb_d  = lrb_q;
    val_d  = val_q;
    irql_d = irql_q;
    arm_d  = arm_q;
    irqp_d = 1'b0;
    if (start) begin
      done_d = 1'b0;
      addr_d = 1'b0;
      lrb_d  = 1'b0;
      irql_d = 1'b0;
      arm_d  = 1'b1;
    end else begin
      if (clr) begin
        done_d = 1'b0;
        addr_d = 1'b0;
        lrb_d  = 1'b0;
        irql_d = 1'b0;
      end
      if (cmpl) begin
        done_d = 1'b1;
        irqp_d = 1'b1;
        irql_d = 1'b1;
        if (arm_q) begin
          addr_d = 1'b1;
          arm_d  = 1'b0;
        end
        if (xmit) begin
          lrb_d = 1'b1;
          val_d = sda_s;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      addr_q <= 1'b0;
      lrb_q  <= 1'b0;
      val_q  <= 1'b0;
      irqp_q <= 1'b0;
      irql_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      addr_q <= addr_d;
      lrb_q  <= lrb_d;
      val_q  <= val_d;
      irqp_q <= irqp_d;
      irql_q <= irql_d;
      arm_q  <= arm_d;
    end
  end

  assign done_o  = done_q;
  assign addr_o  = addr_q;
  assign lrb_o   = lrb_q;
  assign val_o   = val_q;
  assign irq_p_o = irqp_q;
  assign irq_l_o = irql_q;

  // R7: the pulse is one cycle wide and always comes with the level
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    irqp_q |=> !irqp_q);
  a_r7_level_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irqp_q |-> (irql_q && done_q));

  // R5: the address flag only rises when an address byte was armed
  a_r5_addr_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_q) |-> ($past(arm_q) && irqp_q));

  // R6: the bit flag only rises with a completion
  a_r6_lrb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lrb_q) |-> (done_q && irqp_q));

  // R8: a clear without a competing completion empties the flags
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !cmpl) |=> (!done_q && !addr_q && !lrb_q && !irql_q));

endmodule

// File: rtl/i2c_byte_status.sv
module i2c_byte_status #(
  parameter int unsigned DATA_BITS   = i2c_bstat_pkg::BSTAT_DATA_BITS,
  parameter int unsigned SYNC_STAGES = i2c_bstat_pkg::BSTAT_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  input  logic xmit,
  input  logic start_det,
  input  logic stat_clr,
  output logic byte_done,
  output logic addr_flag,
  output logic lrb_flag,
  output logic lrb_val,
  output logic irq_pulse,
  output logic irq_level
);

  logic srst_n;
  logic rise;
  logic cmpl;

  i2c_bstat_rsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  i2c_bstat_edge u_edge (
    .clk   (clk),
    .rst_n (srst_n),
    .scl_s (scl_s),
    .rise  (rise)
  );

  i2c_bstat_count #(.DATA_BITS(DATA_BITS)) u_count (
    .clk   (clk),
    .rst_n (srst_n),
    .rise  (rise),
    .start (start_det),
    .xmit  (xmit),
    .cmpl  (cmpl)
  );

  i2c_bstat_flags u_flags (
    .clk     (clk),
    .rst_n   (srst_n),
    .cmpl    (cmpl),
    .start   (start_det),
    .clr     (stat_clr),
    .xmit    (xmit),
    .sda_s   (sda_s),
    .done_o  (byte_done),
    .addr_o  (addr_flag),
    .lrb_o   (lrb_flag),
    .val_o   (lrb_val),
    .irq_p_o (irq_pulse),
    .irq_l_o (irq_level)
  );

  // R2: a new interrupt needs SCL to have been high in the cycle before
  a_r2_pulse_after_high: assert property (@(posedge clk) disable iff (!srst_n)
    irq_pulse |-> $past(scl_s));

  // R9: a start leaves every sticky flag low
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!srst_n)
    start_det |=> (!byte_done && !addr_flag && !lrb_flag && !irq_level));

endmodule

// File: tb/i2c_byte_status_bench.sv
`timescale 1ns/1ps
module i2c_byte_status_bench;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, scl_s, sda_s, xmit, start_det, stat_clr;
  logic byte_done, addr_flag, lrb_flag, lrb_val, irq_pulse, irq_level;

  i2c_byte_status u_i2c_byte_status (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .xmit(xmit),
    .start_det(start_det), .stat_clr(stat_clr), .byte_done(byte_done),
    .addr_flag(addr_flag), .lrb_flag(lrb_flag), .lrb_val(lrb_val),
    .irq_pulse(irq_pulse), .irq_level(irq_level)
  );

  typedef struct {
    bit d; bit a; bit l; bit v; bit il;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int pushes = 0;
  int pulses = 0;
  bit finished = 0;
  bit prev_pulse = 0;

  int m_cnt = 0;
  bit m_arm = 0, m_d = 0, m_a = 0, m_l = 0, m_v = 0, m_il = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model_clear();
    m_d = 0; m_a = 0; m_l = 0; m_il = 0;
  endfunction

  // called when the driver raises SCL (R2, R3, R4, R5, R6)
  function automatic void model_rise(input bit b);
    exp_t e;
    m_cnt++;
    if (m_cnt == (xmit ? 9 : 8)) begin
      m_d = 1; m_il = 1;
      if (m_arm) begin m_a = 1; m_arm = 0; end
      if (xmit) begin m_l = 1; m_v = b; end
      e.d = m_d; e.a = m_a; e.l = m_l; e.v = m_v; e.il = m_il;
      q.push_back(e);
      pushes++;
    end
    if (m_cnt == 9) m_cnt = 0;
  endfunction

  task automatic bit_clk(input bit b, input bit with_clr);
    @(negedge clk); scl_s = 1'b0; sda_s = b;
    repeat (2) @(negedge clk);
    scl_s = 1'b1;
    if (with_clr) begin stat_clr = 1'b1; model_clear(); end
    model_rise(b);
    @(negedge clk); stat_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit ackb, input bit clr_last);
    for (int i = 7; i >= 0; i--) bit_clk(d[i], 1'b0);
    bit_clk(ackb, clr_last);
  endtask

  task automatic do_clear();
    @(negedge clk); stat_clr = 1'b1; model_clear();
    @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start_det = 1'b1;
    m_cnt = 0; m_arm = 1; model_clear();
    @(negedge clk); start_det = 1'b0;
  endtask

  task automatic check_flags(input string req);
    chk(req, "byte_done", byte_done, m_d);
    chk(req, "addr_flag", addr_flag, m_a);
    chk(req, "lrb_flag", lrb_flag, m_l);
    chk(req, "lrb_val", lrb_val, m_v);
    chk(req, "irq_level", irq_level, m_il);
  endtask

  // scoreboard monitor (R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_pulse) begin
        pulses++;
        chk("R7", "pulse width", int'(prev_pulse), 0);
        if (q.size() == 0) begin
          chk("R7", "unexpected pulse", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R7", "done at pulse", byte_done, e.d);
          chk("R5", "addr at pulse", addr_flag, e.a);
          chk("R6", "lrb at pulse", lrb_flag, e.l);
          chk("R6", "lrb_val at pulse", lrb_val, e.v);
          chk("R7", "level at pulse", irq_level, e.il);
        end
      end
      prev_pulse = irq_pulse;
    end
  end

  initial begin
    rst_n = 1'b0; scl_s = 1'b1; sda_s = 1'b1; xmit = 1'b0;
    start_det = 1'b0; stat_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1", "outputs after reset",
        {byte_done, addr_flag, lrb_flag, lrb_val, irq_pulse, irq_level}, 0);

    // R5 R4: address byte received, completes on edge 8
    do_start();
    check_flags("R9");
    send_frame(8'hA4, 1'b0, 1'b0);
    check_flags("R5");
    chk("R6", "rx leaves lrb_flag", lrb_flag, 0);

    // R8: clear
    do_clear();
    check_flags("R8");
    chk("R8", "flags cleared", {byte_done, addr_flag, lrb_flag, irq_level}, 0);

    // R4: second received byte counts after the ack edge, no address
    send_frame(8'h3C, 1'b0, 1'b0);
    check_flags("R4");
    chk("R5", "no addr on second byte", addr_flag, 0);

    // R2: SCL held high for a long time adds nothing
    repeat (30) @(negedge clk);
    chk("R2", "pulses while high", pulses, pushes);

    // R3 R6: transmit with NACK then ACK
    do_clear();
    xmit = 1'b1;
    send_frame(8'h5A, 1'b1, 1'b0);
    check_flags("R3");
    chk("R6", "lrb_val NACK", lrb_val, 1);
    do_clear();
    send_frame(8'hC3, 1'b0, 1'b0);
    check_flags("R6");
    chk("R6", "lrb_val ACK", lrb_val, 0);

    // R9: start in the middle of a byte
    xmit = 1'b0;
    bit_clk(1'b1, 1'b0); bit_clk(1'b0, 1'b0); bit_clk(1'b1, 1'b0);
    do_start();
    chk("R9", "flags after start", {byte_done, addr_flag, lrb_flag, irq_level}, 0);
    send_frame(8'h81, 1'b0, 1'b0);
    check_flags("R9");
    chk("R9", "address after restart", addr_flag, 1);

    // R8: clear coinciding with a transmit completion; completion wins
    xmit = 1'b1;
    for (int i = 0; i < 8; i++) bit_clk(1'b0, 1'b0);
    bit_clk(1'b1, 1'b1);
    check_flags("R8");
    chk("R8", "done survives clear", byte_done, 1);

    repeat (6) @(negedge clk);
    chk("R7", "queue drained", q.size(), 0);
    chk("R7", "pulse count", pulses, pushes);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule